// File: doc/BRIEF.md
# Two-Wire Block-Write Configuration Receiver

This block is a write-only target on a two-wire serial bus that follows the SMBus block-write framing. A fast system clock oversamples the clock and data lines. The block watches for START and STOP conditions and compares the first byte of each frame against one fixed 7-bit target address. If the address matches and the direction bit asks for a write, the block acknowledges the byte.

After a matched address, the block acknowledges two header bytes, a command code and a byte count, and discards both. Every later byte is a payload byte. The first payload byte goes to register 0, the next to register 1, and so on. Each one leaves the block as a single-cycle write strobe carrying an index and a data byte. A small configuration register file, such as a set of per-output enable bits, sits behind that strobe. Bytes beyond the last register are still acknowledged but produce no strobe.

The write strobe is valid-only and has no back-pressure. The bus cannot be stalled, because this target never holds the clock line low. The register file must therefore accept a strobe in the cycle it appears. The data line is driven only as an open-drain pull-down enable.

Top module: `smb_blkwr_slave`

## Requirements
- R1: A first byte of 1101001 followed by direction bit 0 (byte value 0xD2) is acknowledged. Any other first byte is not acknowledged, and the rest of that frame produces no acknowledge and no write strobe.
- R2: A first byte holding the matching address with direction bit 1 (0xD3) is not acknowledged and opens no data phase.
- R3: The two bytes after a matched address are acknowledged, and their values never affect which registers are written or how.
- R4: Payload bytes produce write strobes with indices 0, 1, 2, … in arrival order, one strobe per byte, carrying that byte.
- R5: A STOP after any complete byte ends the frame. The writes already issued stand, and the next frame starts again at index 0.
- R6: Payload bytes beyond index NUM_REGS-1 are acknowledged and produce no write strobe.
- R7: Bits arrive most significant first: the first data bit sampled becomes bit 7 of the strobe data.
- R8: The general-call address (first byte 0x00) is not acknowledged.
- R9: A START at any point, including inside a byte, aborts the current frame, and the following frame indexes from 0 again.
- R10: A byte cut short by STOP or START produces no write strobe. A write strobe appears only as the acknowledge of a complete payload byte begins.
- R11: The pull-down asserts only after the SCL fall that ends the 8th bit of an accepted byte. It stays on through the 9th SCL high and releases once SCL falls again. At all other times it is off.
- R12: `wr_valid_o` is a one-cycle pulse per accepted payload byte, with no ready input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| wr_valid_o | output | 1 | One-cycle write strobe to the register file |
| wr_idx_o | output | IDX_W | Register index for the strobe |
| wr_data_o | output | 8 | Data byte for the strobe |

## Verification
The hardest situations to reach from the ports are a frame broken off mid-byte and a repeated START arriving while the payload index is non-zero. In both, the block must forget a partly shifted byte and its place in the register sequence. The stimulus drives a master that sends a few bits, then issues a STOP or a new START before the 8th bit. It then starts a fresh frame and checks that the first strobe goes to index 0.

Surplus bytes need a frame longer than the register count. Rejected frames are followed by more bytes, so a stray acknowledge or strobe would show up.

// File: rtl/smb_blkwr_pkg.sv
package smb_blkwr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK
  } phase_t;

  typedef enum logic [1:0] {
    SLOT_ADDR,
    SLOT_CMD,
    SLOT_COUNT,
    SLOT_DATA
  } slot_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  // Conditions are only recognised while SCL stays high across two samples.
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/smb_byte_shift.sv
module smb_byte_shift
  import smb_blkwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o  <= '0;
      bit_cnt <= '0;
    end else if (clear_i) begin
      byte_o  <= '0;
      bit_cnt <= '0;
    end else if (sample_i && !full_o) begin
      byte_o  <= {byte_o[BYTE_W-2:0], bit_i};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign full_o = (bit_cnt == CNT_W'(BYTE_W));

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !clear_i) |=> full_o); // R7
endmodule

// File: rtl/smb_frame_ctrl.sv
module smb_frame_ctrl
  import smb_blkwr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         NUM_REGS    = 3,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int        CNT_W       = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              full_i,
  output logic              sample_o,
  output logic              clear_o,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  phase_t           phase;
  slot_t            slot;
  logic [CNT_W-1:0] data_cnt;
  logic             ack_high_seen;
  logic             ack_done;
  logic             addr_hit;

  assign addr_hit = (byte_i[BYTE_W-1:1] == TARGET_ADDR) && !byte_i[0];
  assign ack_done = (phase == PH_ACK) && scl_fall_i && ack_high_seen;
  assign sample_o = (phase == PH_RECV) && scl_rise_i;
  assign clear_o  = start_i || ack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      slot          <= SLOT_ADDR;
      data_cnt      <= '0;
      ack_high_seen <= 1'b0;
      sda_pull_o    <= 1'b0;
      wr_valid_o    <= 1'b0;
      wr_idx_o      <= '0;
      wr_data_o     <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (start_i) begin
        phase         <= PH_RECV;
        slot          <= SLOT_ADDR;
        data_cnt      <= '0;
        ack_high_seen <= 1'b0;
        sda_pull_o    <= 1'b0;
      end else if (stop_i) begin
        phase      <= PH_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (phase)
          PH_RECV: begin
            if (full_i && scl_fall_i) begin
              ack_high_seen <= 1'b0;
              unique case (slot)
                SLOT_ADDR: begin
                  if (addr_hit) begin
                    phase      <= PH_ACK;
                    sda_pull_o <= 1'b1;
                    slot       <= SLOT_CMD;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                SLOT_CMD: begin
                  phase      <= PH_ACK;
                  sda_pull_o <= 1'b1;
                  slot       <= SLOT_COUNT;
                end
                SLOT_COUNT: begin
                  phase      <= PH_ACK;
                  sda_pull_o <= 1'b1;
                  slot       <= SLOT_DATA;
                end
                SLOT_DATA: begin
                  phase      <= PH_ACK;
                  sda_pull_o <= 1'b1;
                  if (data_cnt < CNT_W'(NUM_REGS)) begin
                    wr_valid_o <= 1'b1;
                    wr_idx_o   <= data_cnt[IDX_W-1:0];
                    wr_data_o  <= byte_i;
                    data_cnt   <= data_cnt + 1'b1;
                  end
                end
                default: phase <= PH_IDLE;
              endcase
            end
          end
          PH_ACK: begin
            if (scl_rise_i) ack_high_seen <= 1'b1;
            if (ack_done) begin
              sda_pull_o <= 1'b0;
              phase      <= PH_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_PULL_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall_i)); // R11
  AST_PULL_ENDS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(scl_fall_i || start_i || stop_i)); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull_o); // R1
  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (int'(wr_idx_o) < NUM_REGS)); // R6
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o); // R12
  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $rose(sda_pull_o)); // R10
endmodule

// File: rtl/smb_blkwr_slave.sv
module smb_blkwr_slave
  import smb_blkwr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         NUM_REGS    = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              wr_valid_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  raw_lines;
  logic [LINES-1:0]  sync_lines;
  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0] shift_byte;
  logic              shift_full, shift_sample, shift_clear;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines[g]),
      .q_o   (sync_lines[g])
    );
  end

  smb_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s_i    (sync_lines[1]),
    .sda_s_i    (sync_lines[0]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  smb_byte_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (shift_clear),
    .sample_i (shift_sample),
    .bit_i    (sync_lines[0]),
    .byte_o   (shift_byte),
    .full_o   (shift_full)
  );

  smb_frame_ctrl #(.TARGET_ADDR(TARGET_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .byte_i     (shift_byte),
    .full_i     (shift_full),
    .sample_o   (shift_sample),
    .clear_o    (shift_clear),
    .sda_pull_o (sda_pull_o),
    .wr_valid_o (wr_valid_o),
    .wr_idx_o   (wr_idx_o),
    .wr_data_o  (wr_data_o)
  );
endmodule

// File: tb/smb_blkwr_slave_tb.sv
module smb_blkwr_slave_tb;
  localparam int NREG  = 3;
  localparam int HALF  = 16;
  localparam int LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic       wr_valid;
  logic [1:0] wr_idx;
  logic [7:0] wr_data;
  wire        sda_bus = sda_m & ~sda_pull;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] expq[$];
  int  m_listen = 0;
  int  m_slot = 0;
  int  m_idx = 0;

  always #2.5 clk = ~clk;

  smb_blkwr_slave #(.TARGET_ADDR(7'h69), .NUM_REGS(NREG), .SYNC_STAGES(2)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull),
    .wr_valid_o (wr_valid),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  // Per-clock comparison of the write stream against the model queue.
  always @(negedge clk) begin
    if (rst_n && !done && wr_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R6/R10", "unexpected write strobe idx", int'(wr_idx), -1);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(wr_idx == e[9:8], "R4", "write index", int'(wr_idx), int'(e[9:8]));
        chk(wr_data == e[7:0], "R7", "write data", int'(wr_data), int'(e[7:0]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic bus_start();
    scl_m = 1'b0; wclk(6); sda_m = 1'b1; wclk(HALF);
    scl_m = 1'b1; wclk(HALF); sda_m = 1'b0; wclk(HALF);
    m_listen = 1; m_slot = 0; m_idx = 0;
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wclk(6); sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b1; wclk(HALF); sda_m = 1'b1; wclk(HALF);
    m_listen = 0;
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl_m = 1'b0; wclk(6); sda_m = b[i]; wclk(HALF - 6);
      scl_m = 1'b1; wclk(HALF / 2);
      chk(sda_pull == 1'b0, "R11", "pull during data bit", int'(sda_pull), 0);
      wclk(HALF / 2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, string req);
    bit exp_ack;
    exp_ack = 1'b0;
    if (m_listen != 0) begin
      if (m_slot == 0) begin
        exp_ack = (b == 8'hD2);
        if (!exp_ack) m_listen = 0;
        m_slot = 1;
      end else if (m_slot < 3) begin
        exp_ack = 1'b1;
        m_slot++;
      end else begin
        exp_ack = 1'b1;
        if (m_idx < NREG) begin
          expq.push_back({6'd0, 2'(m_idx), b});
          m_idx++;
        end
      end
    end
    send_bits(b, 8);
    scl_m = 1'b0; wclk(6); sda_m = 1'b1; wclk(HALF - 6);
    scl_m = 1'b1; wclk(HALF / 2);
    chk(sda_pull == exp_ack, req, "acknowledge", int'(sda_pull), int'(exp_ack));
    wclk(HALF / 2);
  endtask

  task automatic drained(string req);
    wclk(8);
    chk(expq.size() == 0, req, "pending expected writes", expq.size(), 0);
  endtask

  initial begin
    wclk(4);
    chk(sda_pull == 1'b0, "R11", "reset pull", int'(sda_pull), 0);
    chk(wr_valid == 1'b0, "R12", "reset strobe", int'(wr_valid), 0);
    rst_n = 1'b1;
    wclk(10);

    // R1 R3 R4 R7: full frame, header values unrelated to payload length
    bus_start();
    send_byte(8'hD2, "R1");
    send_byte(8'h5A, "R3");
    send_byte(8'h07, "R3");
    send_byte(8'hA5, "R4");
    send_byte(8'h3C, "R4");
    send_byte(8'h81, "R7");
    bus_stop();
    drained("R4");

    // R6: surplus bytes acknowledged, no strobe
    bus_start();
    send_byte(8'hD2, "R1");
    send_byte(8'h00, "R3");
    send_byte(8'h05, "R3");
    send_byte(8'h11, "R4");
    send_byte(8'h22, "R4");
    send_byte(8'h33, "R4");
    send_byte(8'h44, "R6");
    send_byte(8'h55, "R6");
    bus_stop();
    drained("R6");

    // R1: wrong address, following bytes ignored
    bus_start();
    send_byte(8'hD4, "R1");
    send_byte(8'h00, "R1");
    send_byte(8'h01, "R1");
    send_byte(8'hFF, "R1");
    bus_stop();
    drained("R1");

    // R2: read direction
    bus_start();
    send_byte(8'hD3, "R2");
    send_byte(8'h00, "R2");
    send_byte(8'h01, "R2");
    send_byte(8'h99, "R2");
    bus_stop();
    drained("R2");

    // R8: general call
    bus_start();
    send_byte(8'h00, "R8");
    send_byte(8'h00, "R8");
    bus_stop();
    drained("R8");

    // R5: stop after one payload byte, next frame restarts at index 0
    bus_start();
    send_byte(8'hD2, "R1");
    send_byte(8'h00, "R3");
    send_byte(8'h01, "R3");
    send_byte(8'hC3, "R5");
    bus_stop();
    drained("R5");
    bus_start();
    send_byte(8'hD2, "R5");
    send_byte(8'h00, "R3");
    send_byte(8'h02, "R3");
    send_byte(8'h6E, "R5");
    bus_stop();
    drained("R5");

    // R10: byte cut short by STOP gives no write
    bus_start();
    send_byte(8'hD2, "R1");
    send_byte(8'h00, "R3");
    send_byte(8'h03, "R3");
    send_byte(8'h12, "R4");
    send_bits(8'hF0, 5);
    bus_stop();
    drained("R10");

    // R9 R10: repeated START inside a byte aborts; new frame from index 0
    bus_start();
    send_byte(8'hD2, "R1");
    send_byte(8'h00, "R3");
    send_byte(8'h03, "R3");
    send_byte(8'h9A, "R4");
    send_byte(8'h9B, "R4");
    send_bits(8'h0F, 3);
    bus_start();
    send_byte(8'hD2, "R9");
    send_byte(8'h00, "R3");
    send_byte(8'h01, "R3");
    send_byte(8'h77, "R9");
    // R9: repeated START on a byte boundary
    bus_start();
    send_byte(8'hD2, "R9");
    send_byte(8'h00, "R3");
    send_byte(8'h01, "R3");
    send_byte(8'h88, "R9");
    bus_stop();
    drained("R9");

    wclk(20);
    chk(sda_pull == 1'b0, "R11", "idle pull", int'(sda_pull), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule